// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

The exchanger moves data in either direction, on one clock, between a narrow port A and a wide port split into two halves, 1B and 2B, each as wide as A. In the A-to-B direction it gathers two consecutive narrow words. The first goes through a holding stage. The second is captured together with the held word, so both halves of the wide side update on the same edge. In the B-to-A direction both wide halves are stored on every edge, and a select input chooses which stored half appears on A.

The direction input is registered. A change of direction therefore takes effect only after a rising clock edge. While a change is pending, neither side drives, which gives a clean turnaround. An active-low output enable switches off all driving. Three-state pins are modelled as separate data-out and drive-enable signals.

Top module: `bus_exchanger`

## Requirements
- R1: While rst_ni is low, all data registers and the registered direction are zero, so b1_o, b2_o and a_o read 0. With oe_ni low and dir_i low during reset, a_oe_o is 1 and b_oe_o is 0.
- R2: Whenever oe_ni is 1, a_oe_o and b_oe_o are both 0.
- R3: The registered direction takes the value of dir_i on each rising edge (1 = A-to-B, 0 = B-to-A). While dir_i differs from the registered direction, a_oe_o and b_oe_o are both 0, and the two are never 1 together.
- R4: With oe_ni low and dir_i equal to the registered direction, b_oe_o = 1 and a_oe_o = 0 for direction 1, and a_oe_o = 1 and b_oe_o = 0 for direction 0.
- R5: On an edge with registered direction 1 and sel_i low, a_i is loaded into the holding stage, and b1_o and b2_o keep their values.
- R6: On an edge with registered direction 1 and sel_i high, b1_o takes the held word and b2_o takes the current a_i, both on that same edge.
- R7: On an edge with registered direction 0, b1_i and b2_i are both stored. a_o shows the stored 1B half when sel_i is 0 and the stored 2B half when sel_i is 1; the choice follows sel_i without waiting for a clock.
- R8: While the registered direction is 1, the B-to-A storage holds its value. While it is 0, b1_o and b2_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Requested direction: 1 A-to-B, 0 B-to-A |
| sel_i | input | 1 | Gather phase (A-to-B) or half select (B-to-A) |
| oe_ni | input | 1 | Output enable, active low |
| a_i | input | W | Narrow port input data |
| b1_i | input | W | Wide half 1B input data |
| b2_i | input | W | Wide half 2B input data |
| a_o | output | W | Narrow port output data |
| a_oe_o | output | 1 | Narrow port drive enable |
| b1_o | output | W | Wide half 1B output data |
| b2_o | output | W | Wide half 2B output data |
| b_oe_o | output | 1 | Wide port drive enable (both halves) |

## Verification
On every cycle, the assertions check the drive-enable rules: no driving while disabled, no driving during a pending turnaround, and never both sides at once. They also check that the 2B half captures a_i on the pairing edge and that the B halves stay frozen on gather edges and in the B-to-A direction. Only the bench's scenarios show that 1B and 2B pair words in their arrival order across every value pair. The bench also shows that the stored B halves come back on A under both select values, and that the reset state is correct.

// File: rtl/exch_pkg.sv
package exch_pkg;
  typedef enum logic {
    DIR_B2A = 1'b0,
    DIR_A2B = 1'b1
  } dir_e;
endpackage

// File: rtl/exch_drive_ctl.sv
module exch_drive_ctl
  import exch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic oe_ni,
  output dir_e dir_q_o,
  output logic a_oe_o,
  output logic b_oe_o
);
  dir_e dir_q;
  logic settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_B2A;
    else         dir_q <= dir_e'(dir_i);
  end

  // pending direction change blanks both sides
  assign settled = (dir_e'(dir_i) == dir_q);
  assign a_oe_o  = !oe_ni && settled && (dir_q == DIR_B2A);
  assign b_oe_o  = !oe_ni && settled && (dir_q == DIR_A2B);
  assign dir_q_o = dir_q;
endmodule

// File: rtl/exch_ab_path.sv
module exch_ab_path #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  logic [W-1:0] hold_q, b1_q, b2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
    end else if (en_i) begin
      if (!sel_i) begin
        hold_q <= a_i;
      end else begin
        b1_q <= hold_q;
        b2_q <= a_i;
      end
    end
  end

  assign b1_o = b1_q;
  assign b2_o = b2_q;
endmodule

// File: rtl/exch_ba_path.sv
module exch_ba_path #(
  parameter int W      = 18,
  parameter int HALVES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] a_o
);
  localparam int SW = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic [W-1:0] half_in [HALVES];
  logic [W-1:0] store_q [HALVES];
  logic [SW-1:0] pick;

  assign half_in[0] = b1_i;
  assign half_in[1] = b2_i;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   store_q[h] <= '0;
      else if (en_i) store_q[h] <= half_in[h];
    end
  end

  assign pick = SW'(sel_i);
  assign a_o  = store_q[pick];
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import exch_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_i,
  input  logic         sel_i,
  input  logic         oe_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o,
  output logic         b_oe_o
);
  dir_e dir_q;

  exch_drive_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_i   (dir_i),
    .oe_ni   (oe_ni),
    .dir_q_o (dir_q),
    .a_oe_o  (a_oe_o),
    .b_oe_o  (b_oe_o)
  );

  exch_ab_path #(.W(W)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dir_q == DIR_A2B),
    .sel_i  (sel_i),
    .a_i    (a_i),
    .b1_o   (b1_o),
    .b2_o   (b2_o)
  );

  exch_ba_path #(.W(W), .HALVES(2)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dir_q == DIR_B2A),
    .sel_i  (sel_i),
    .b1_i   (b1_i),
    .b2_i   (b2_i),
    .a_o    (a_o)
  );
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         dir_i,
  input logic         sel_i,
  input logic         oe_ni,
  input logic [W-1:0] a_i,
  input logic         a_oe_o,
  input logic [W-1:0] b1_o,
  input logic [W-1:0] b2_o,
  input logic         b_oe_o,
  input logic         dir_q
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));

  // R3
  turnaround_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i != dir_q) |-> (!a_oe_o && !b_oe_o));

  // R3
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  // R6
  pair_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q && sel_i) |=> (b2_o == $past(a_i)));

  // R5
  gather_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q && !sel_i) |=> ($stable(b1_o) && $stable(b2_o)));

  // R8
  b_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_q |=> ($stable(b1_o) && $stable(b2_o)));
endmodule

bind bus_exchanger bus_exchanger_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dir_i  (dir_i),
  .sel_i  (sel_i),
  .oe_ni  (oe_ni),
  .a_i    (a_i),
  .a_oe_o (a_oe_o),
  .b1_o   (b1_o),
  .b2_o   (b2_o),
  .b_oe_o (b_oe_o),
  .dir_q  (dir_q)
);

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_ni, dir_i, sel_i, oe_ni;
  logic [W-1:0] a_i, b1_i, b2_i, a_o, b1_o, b2_o;
  logic a_oe_o, b_oe_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_exchanger #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dir_i(dir_i), .sel_i(sel_i), .oe_ni(oe_ni),
    .a_i(a_i), .b1_i(b1_i), .b2_i(b2_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b1_o(b1_o), .b2_o(b2_o), .b_oe_o(b_oe_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int eb1, eb2;
    rst_ni = 1'b0; dir_i = 1'b0; sel_i = 1'b0; oe_ni = 1'b1;
    a_i = '0; b1_i = '0; b2_i = '0;
    #3;
    // R1 reset state
    chk("R1 b1", b1_o, 0);
    chk("R1 b2", b2_o, 0);
    chk("R1 a", a_o, 0);
    chk("R2 a_oe in reset", a_oe_o, 0);
    chk("R2 b_oe in reset", b_oe_o, 0);
    oe_ni = 1'b0; #1;
    chk("R1 a_oe", a_oe_o, 1);
    chk("R1 b_oe", b_oe_o, 0);
    step(); step();
    rst_ni = 1'b1;
    step();
    oe_ni = 1'b1; #1;
    chk("R2 a_oe", a_oe_o, 0);
    chk("R2 b_oe", b_oe_o, 0);
    oe_ni = 1'b0;

    // turnaround to A-to-B
    dir_i = 1'b1; #1;
    chk("R3 a_oe pending", a_oe_o, 0);
    chk("R3 b_oe pending", b_oe_o, 0);
    step();
    chk("R4 b_oe", b_oe_o, 1);
    chk("R4 a_oe", a_oe_o, 0);

    // R5/R6 sweep all word pairs
    eb1 = 0; eb2 = 0;
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        a_i = W'(x); sel_i = 1'b0;
        step();
        chk("R5 b1 hold", b1_o, eb1);
        chk("R5 b2 hold", b2_o, eb2);
        a_i = W'(y); sel_i = 1'b1;
        step();
        eb1 = x; eb2 = y;
        chk("R6 b1 first word", b1_o, x);
        chk("R6 b2 second word", b2_o, y);
        chk("R8 a store held", a_o, 0);
      end
    end

    // turnaround to B-to-A; sel low so B halves stay put
    sel_i = 1'b0; dir_i = 1'b0; #1;
    chk("R3 a_oe pending", a_oe_o, 0);
    chk("R3 b_oe pending", b_oe_o, 0);
    step();
    chk("R4 a_oe", a_oe_o, 1);
    chk("R4 b_oe", b_oe_o, 0);

    // R7 sweep
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        b1_i = W'(x); b2_i = W'(y); a_i = W'(x ^ y);
        sel_i = 1'b1;
        step();
        sel_i = 1'b0; #1;
        chk("R7 sel0 1B", a_o, x);
        sel_i = 1'b1; #1;
        chk("R7 sel1 2B", a_o, y);
        chk("R8 b1 frozen", b1_o, eb1);
        chk("R8 b2 frozen", b2_o, eb2);
      end
    end

    oe_ni = 1'b1; #1;
    chk("R2 a_oe end", a_oe_o, 0);
    chk("R2 b_oe end", b_oe_o, 0);
    finish_run();
  end
endmodule